// File: doc/BRIEF.md
# SONET Framing Byte Corruptor

This block sits in the transmit byte path of up to four channels carrying SONET frames and deliberately damages the framing pattern so that a far-end receiver's loss-of-frame handling can be exercised. Each channel delivers a byte stream with a valid strobe and a start-of-frame marker. The first 12 valid bytes of a frame form the A1 field and the next 12 form the A2 field.

A per-channel trigger bit starts a burst on its rising edge. The burst begins at the next frame start. For a programmable number of consecutive frames, every A1 byte is replaced by a shared A1 substitute value and every A2 byte by a shared A2 substitute value. The burst length and both substitute values are shared by all channels; the trigger bits select which channels are hit. All other bytes pass through unchanged. Both paths have one register stage of latency. A per-channel busy flag marks a burst in progress.

Top module: `sonet_fa_corruptor`

## Requirements
- R1: While reset is asserted, `out_valid`, `out_sof`, `out_data` and `busy` are all zero.
- R2: A valid byte that is not replaced appears on `out_data` one clock later, unchanged. `out_valid` and `out_sof` follow `in_valid` and `in_sof` one clock later.
- R3: A 0-to-1 change of a channel's `inject_cmd` arms that channel. Corruption starts with the first frame start seen on a clock after the edge clock. A frame whose start marker comes on the edge clock itself is left intact.
- R4: In a corrupted frame, valid byte positions 0 to 11 after the start marker are output as `a1_sub`, and positions 12 to 23 are output as `a2_sub`. Position 24 onward is untouched.
- R5: A burst corrupts exactly the number of consecutive frames held in `burst_len` on the edge clock. Later changes to `burst_len` do not alter a burst already armed.
- R6: An edge while `burst_len` is 0 corrupts nothing, and `busy` stays low.
- R7: Holding `inject_cmd` high never starts another burst. An edge that arrives while a burst is in progress is ignored. A new burst needs a fresh 0-to-1 change after the channel has gone idle.
- R8: `busy` rises on the clock after an accepted edge. It falls in the same cycle that the last replaced A2 byte of the final frame appears at the output.
- R9: Channels run independently. A trigger on one channel never alters another channel's output.
- R10: Cycles with `in_valid` low neither advance the byte position nor count toward a frame, and `out_data` holds its last value through them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_data | input | NUM_CH*8 | Input bytes, channel c in bits [8c+7:8c] |
| in_valid | input | NUM_CH | Per-channel byte valid |
| in_sof | input | NUM_CH | Per-channel start of frame, marks the first A1 byte |
| inject_cmd | input | NUM_CH | Per-channel trigger, acts on its rising edge |
| burst_len | input | 4 | Shared number of frames to corrupt |
| a1_sub | input | 8 | Shared replacement value for A1 bytes |
| a2_sub | input | 8 | Shared replacement value for A2 bytes |
| out_data | output | NUM_CH*8 | Output bytes, one clock after input |
| out_valid | output | NUM_CH | Delayed byte valid |
| out_sof | output | NUM_CH | Delayed start of frame |
| busy | output | NUM_CH | Burst armed or in progress |

## Verification
Each channel has a small set of internal state: an armed/running state, a frame countdown and a byte position. A wrong value in any of them shows up at the ports within one frame. A stuck position counter shifts the replaced window off bytes 0 to 23, which shows up on the very next corrupted byte. A wrong countdown changes how many frame-start bytes carry `a1_sub`, and it moves the fall of `busy` by at least one whole frame. A missed edge mask shows up as extra bursts while the trigger is held high. The scoreboard compares every output byte, strobe and busy bit on every cycle, so these faults are caught on the first wrong cycle.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef enum logic [1:0] {
    BST_IDLE = 2'd0,
    BST_WAIT = 2'd1,
    BST_RUN  = 2'd2
  } burst_state_e;

endpackage

// File: rtl/sfc_rst_sync.sv
module sfc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sfc_field_tracker.sv
module sfc_field_tracker #(
  parameter int A1_LEN = 12,
  parameter int A2_LEN = 12,
  localparam int FIELD_LEN = A1_LEN + A2_LEN,
  localparam int POS_W = $clog2(FIELD_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid_i,
  input  logic sof_i,
  output logic in_field_o,
  output logic a2_zone_o,
  output logic field_last_o
);

  localparam logic [POS_W-1:0] FIELD_END = POS_W'(FIELD_LEN);
  localparam logic [POS_W-1:0] A2_START  = POS_W'(A1_LEN);
  localparam logic [POS_W-1:0] LAST_POS  = POS_W'(FIELD_LEN - 1);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_d;
  logic [POS_W-1:0] cur_pos;
  logic             pos_en;

  // position of the byte present this cycle
  assign cur_pos = (valid_i && sof_i) ? '0 : pos_q;
  assign pos_en  = valid_i;

  always_comb begin
    pos_d = pos_q;
    if (cur_pos < FIELD_END) begin
      pos_d = cur_pos + 1'b1;
    end else begin
      pos_d = FIELD_END;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= FIELD_END;
    end else if (pos_en) begin
      pos_q <= pos_d;
    end
  end

  assign in_field_o   = valid_i && (cur_pos < FIELD_END);
  assign a2_zone_o    = cur_pos >= A2_START;
  assign field_last_o = valid_i && (cur_pos == LAST_POS);

  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= FIELD_END); // R4
  AST_POS_HOLD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(pos_q)); // R10

endmodule

// File: rtl/sfc_burst_ctrl.sv
module sfc_burst_ctrl
  import sfc_pkg::*;
#(
  parameter int FCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_i,
  input  logic [FCNT_W-1:0] len_i,
  input  logic              valid_i,
  input  logic              sof_i,
  input  logic              in_field_i,
  input  logic              field_last_i,
  output logic              corrupt_o,
  output logic              busy_o
);

  burst_state_e      st_q;
  burst_state_e      st_d;
  logic [FCNT_W-1:0] rem_q;
  logic [FCNT_W-1:0] rem_d;
  logic              cmd_q;
  logic              rise;

  assign rise = cmd_i && !cmd_q;

  always_comb begin
    st_d  = st_q;
    rem_d = rem_q;
    case (st_q)
      BST_IDLE: begin
        if (rise && (len_i != '0)) begin
          st_d  = BST_WAIT;
          rem_d = len_i;
        end
      end
      BST_WAIT: begin
        if (valid_i && sof_i) begin
          st_d = BST_RUN;
        end
      end
      BST_RUN: begin
        if (field_last_i) begin
          rem_d = rem_q - 1'b1;
          if (rem_q == FCNT_W'(1)) begin
            st_d = BST_IDLE;
          end
        end
      end
      default: begin
        st_d = BST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BST_IDLE;
      rem_q <= '0;
      cmd_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      rem_q <= rem_d;
      cmd_q <= cmd_i;
    end
  end

  assign corrupt_o = in_field_i &&
                     ((st_q == BST_RUN) || ((st_q == BST_WAIT) && valid_i && sof_i));
  assign busy_o    = (st_q != BST_IDLE);

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(rise && (len_i != '0))); // R3
  AST_ZERO_LEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == BST_IDLE) && (len_i == '0)) |=> (st_q == BST_IDLE)); // R6
  AST_REMAIN_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (rem_q != '0)); // R5
  AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BST_RUN) |=> (st_q != BST_WAIT)); // R7

endmodule

// File: rtl/sfc_byte_stage.sv
module sfc_byte_stage #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic              in_valid_i,
  input  logic              in_sof_i,
  input  logic              corrupt_i,
  input  logic              a2_zone_i,
  input  logic [BYTE_W-1:0] a1_val_i,
  input  logic [BYTE_W-1:0] a2_val_i,
  output logic [BYTE_W-1:0] out_data_o,
  output logic              out_valid_o,
  output logic              out_sof_o
);

  logic [BYTE_W-1:0] data_q;
  logic [BYTE_W-1:0] data_d;
  logic              data_en;
  logic              valid_q;
  logic              sof_q;

  assign data_en = in_valid_i;

  always_comb begin
    data_d = in_data_i;
    if (corrupt_i) begin
      data_d = a2_zone_i ? a2_val_i : a1_val_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      sof_q   <= 1'b0;
    end else begin
      valid_q <= in_valid_i;
      sof_q   <= in_sof_i && in_valid_i;
    end
  end

  assign out_data_o  = data_q;
  assign out_valid_o = valid_q;
  assign out_sof_o   = sof_q;

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && !corrupt_i) |=> (out_data_o == $past(in_data_i))); // R2
  AST_HOLD_ON_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> $stable(out_data_o)); // R10

endmodule

// File: rtl/sonet_fa_corruptor.sv
module sonet_fa_corruptor #(
  parameter int NUM_CH = 4,
  parameter int BYTE_W = 8,
  parameter int A1_LEN = 12,
  parameter int A2_LEN = 12,
  parameter int FCNT_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH*BYTE_W-1:0] in_data,
  input  logic [NUM_CH-1:0]        in_valid,
  input  logic [NUM_CH-1:0]        in_sof,
  input  logic [NUM_CH-1:0]        inject_cmd,
  input  logic [FCNT_W-1:0]        burst_len,
  input  logic [BYTE_W-1:0]        a1_sub,
  input  logic [BYTE_W-1:0]        a2_sub,
  output logic [NUM_CH*BYTE_W-1:0] out_data,
  output logic [NUM_CH-1:0]        out_valid,
  output logic [NUM_CH-1:0]        out_sof,
  output logic [NUM_CH-1:0]        busy
);

  logic rst_sync_n;

  sfc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic in_field;
    logic a2_zone;
    logic field_last;
    logic corrupt;

    sfc_field_tracker #(
      .A1_LEN (A1_LEN),
      .A2_LEN (A2_LEN)
    ) u_track (
      .clk          (clk),
      .rst_n        (rst_sync_n),
      .valid_i      (in_valid[ch]),
      .sof_i        (in_sof[ch]),
      .in_field_o   (in_field),
      .a2_zone_o    (a2_zone),
      .field_last_o (field_last)
    );

    sfc_burst_ctrl #(
      .FCNT_W (FCNT_W)
    ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_sync_n),
      .cmd_i        (inject_cmd[ch]),
      .len_i        (burst_len),
      .valid_i      (in_valid[ch]),
      .sof_i        (in_sof[ch]),
      .in_field_i   (in_field),
      .field_last_i (field_last),
      .corrupt_o    (corrupt),
      .busy_o       (busy[ch])
    );

    sfc_byte_stage #(
      .BYTE_W (BYTE_W)
    ) u_stage (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .in_data_i   (in_data[ch*BYTE_W +: BYTE_W]),
      .in_valid_i  (in_valid[ch]),
      .in_sof_i    (in_sof[ch]),
      .corrupt_i   (corrupt),
      .a2_zone_i   (a2_zone),
      .a1_val_i    (a1_sub),
      .a2_val_i    (a2_sub),
      .out_data_o  (out_data[ch*BYTE_W +: BYTE_W]),
      .out_valid_o (out_valid[ch]),
      .out_sof_o   (out_sof[ch])
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_sync_n |-> (!out_valid[ch] && !busy[ch])); // R1
  end

endmodule

// File: tb/sonet_fa_corruptor_tb.sv
module sonet_fa_corruptor_tb_top;

  localparam int NCH = 4;
  localparam int FL  = 40;

  typedef struct packed {
    logic [NCH*8-1:0] data;
    logic [NCH-1:0]   vld;
    logic [NCH-1:0]   sof;
    logic [NCH-1:0]   bsy;
    logic [NCH-1:0]   hit;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NCH*8-1:0] in_data;
  logic [NCH-1:0]   in_valid;
  logic [NCH-1:0]   in_sof;
  logic [NCH-1:0]   inject_cmd;
  logic [3:0]       burst_len;
  logic [7:0]       a1_sub;
  logic [7:0]       a2_sub;
  logic [NCH*8-1:0] out_data;
  logic [NCH-1:0]   out_valid;
  logic [NCH-1:0]   out_sof;
  logic [NCH-1:0]   busy;

  always #10 clk = ~clk;

  sonet_fa_corruptor #(.NUM_CH(NCH)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .inject_cmd (inject_cmd),
    .burst_len  (burst_len),
    .a1_sub     (a1_sub),
    .a2_sub     (a2_sub),
    .out_data   (out_data),
    .out_valid  (out_valid),
    .out_sof    (out_sof),
    .busy       (busy)
  );

  int total = 0;
  int bad   = 0;
  exp_t exp_q[$];

  logic [NCH-1:0] cmd_r;
  logic [3:0]     len_r;
  int             cyc;
  int             idx[NCH];
  int             m_st[NCH];
  int             m_rem[NCH];
  int             m_pos[NCH];
  bit             m_cmdp[NCH];
  logic [7:0]     m_last[NCH];
  int             exp_frames[NCH];
  int             obs_frames[NCH];

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, expv, $time);
    end
  endtask

  // driver: one cycle of stimulus plus expected result into the scoreboard
  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      @(negedge clk);
      cyc++;
      for (int ch = 0; ch < NCH; ch++) begin
        bit         v;
        bit         s;
        bit         rise;
        bit         h;
        int         pcur;
        logic [7:0] d;
        v = (ch == 2) ? ((cyc % 5) != 4) : 1'b1;
        if (v) begin
          s = (idx[ch] == 0);
          if (idx[ch] < 12)      d = 8'hF6;
          else if (idx[ch] < 24) d = 8'h28;
          else                   d = 8'(idx[ch] * 7 + ch * 16 + cyc);
          idx[ch] = (idx[ch] + 1) % FL;
        end else begin
          s = 1'b0;
          d = 8'(cyc * 3);
        end
        in_data[ch*8 +: 8] = d;
        in_valid[ch]       = v;
        in_sof[ch]         = s;
        inject_cmd[ch]     = cmd_r[ch];
        // reference model
        pcur = s ? 0 : m_pos[ch];
        h = v && (pcur < 24) && ((m_st[ch] == 2) || ((m_st[ch] == 1) && s));
        if (v) m_last[ch] = h ? ((pcur >= 12) ? a2_sub : a1_sub) : d;
        if (h && pcur == 0) exp_frames[ch]++;
        if (v) m_pos[ch] = (pcur < 24) ? pcur + 1 : 24;
        rise = cmd_r[ch] && !m_cmdp[ch];
        m_cmdp[ch] = cmd_r[ch];
        case (m_st[ch])
          0: if (rise && len_r != 0) begin m_st[ch] = 1; m_rem[ch] = int'(len_r); end
          1: if (v && s) m_st[ch] = 2;
          default: if (v && pcur == 23) begin
            m_rem[ch]--;
            if (m_rem[ch] == 0) m_st[ch] = 0;
          end
        endcase
        e.data[ch*8 +: 8] = m_last[ch];
        e.vld[ch] = v;
        e.sof[ch] = s;
        e.bsy[ch] = (m_st[ch] != 0);
        e.hit[ch] = h;
      end
      burst_len = len_r;
      exp_q.push_back(e);
    end
  endtask

  // monitor: pops one expected item per cycle, after the design's edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        for (int ch = 0; ch < NCH; ch++) begin
          check(out_data[ch*8 +: 8] == e.data[ch*8 +: 8],
                e.hit[ch] ? "R4 replaced byte" : "R2 R10 passed byte",
                32'(out_data[ch*8 +: 8]), 32'(e.data[ch*8 +: 8]));
          check(out_valid[ch] == e.vld[ch], "R2 valid delay",
                32'(out_valid[ch]), 32'(e.vld[ch]));
          check(out_sof[ch] == e.sof[ch], "R2 sof delay",
                32'(out_sof[ch]), 32'(e.sof[ch]));
          check(busy[ch] == e.bsy[ch], "R8 busy",
                32'(busy[ch]), 32'(e.bsy[ch]));
          if (out_valid[ch] && out_sof[ch] && out_data[ch*8 +: 8] == a1_sub)
            obs_frames[ch]++;
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic frame_check(input int ch, input int want, input string tag);
    check(exp_frames[ch] == want, {tag, " model frame count"}, 32'(exp_frames[ch]), 32'(want));
    check(obs_frames[ch] == want, {tag, " observed frame count"}, 32'(obs_frames[ch]), 32'(want));
  endtask

  initial begin
    rst_n = 1'b0;
    in_data = '0; in_valid = '0; in_sof = '0; inject_cmd = '0;
    burst_len = '0; a1_sub = 8'h5A; a2_sub = 8'hC3;
    cmd_r = '0; len_r = 4'd3; cyc = 0;
    for (int ch = 0; ch < NCH; ch++) begin
      idx[ch] = ch * 5; m_st[ch] = 0; m_rem[ch] = 0; m_pos[ch] = 24;
      m_cmdp[ch] = 1'b0; m_last[ch] = 8'h00; exp_frames[ch] = 0; obs_frames[ch] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: quiet outputs during reset
    check(out_valid == '0, "R1 valid in reset", 32'(out_valid), 0);
    check(out_sof == '0, "R1 sof in reset", 32'(out_sof), 0);
    check(out_data == '0, "R1 data in reset", out_data, 0);
    check(busy == '0, "R1 busy in reset", 32'(busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: plain pass-through
    step(100);

    // R4 R5 R8: three-frame burst on channel 0
    cmd_r[0] = 1'b1;
    step(200);
    frame_check(0, 3, "R5 burst of three");

    // R7: held command does not retrigger
    step(150);
    frame_check(0, 3, "R7 held command");

    // R7 R5: re-arm, then an edge during the burst is ignored, length change ignored
    cmd_r[0] = 1'b0; step(1);
    cmd_r[0] = 1'b1; step(1);
    step(30);
    check(busy[0] == 1'b1, "R8 busy during burst", 32'(busy[0]), 1);
    len_r = 4'd2;
    cmd_r[0] = 1'b0; step(2);
    cmd_r[0] = 1'b1; step(1);
    step(200);
    frame_check(0, 6, "R7 R5 re-arm once");

    // R6: zero length
    len_r = 4'd0;
    cmd_r[1] = 1'b1;
    step(120);
    frame_check(1, 0, "R6 zero length");
    check(busy[1] == 1'b0, "R6 busy stays low", 32'(busy[1]), 0);

    // R10 R9: gapped channel burst, other channels untouched
    len_r = 4'd2;
    cmd_r[2] = 1'b1;
    step(260);
    frame_check(2, 2, "R10 gapped burst");
    frame_check(0, 6, "R9 neighbour unchanged");

    // R3: edge on the same clock as a frame start
    len_r = 4'd1;
    while (idx[3] != 0) step(1);
    cmd_r[3] = 1'b1;
    step(1);
    @(posedge clk); #3;
    check(out_sof[3] && out_data[31:24] == 8'hF6, "R3 edge-clock frame intact",
          32'(out_data[31:24]), 32'hF6);
    step(100);
    frame_check(3, 1, "R3 next frame hit");

    step(5);
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule